// File: doc/BRIEF.md
# Predicate Gate for Conditional Execution

This unit decides, for each instruction word presented to it, whether that instruction is allowed to take effect. The four most significant bits of the word select one of sixteen predicates. Each predicate is a test on the four status flags: negative, zero, carry and overflow. The result is a single enable that the surrounding pipeline uses to gate write-back and every other side effect of the instruction. One code always passes. The top code is reserved: it never passes and raises a separate indication instead.

The flags are held in a small register inside the unit. The register loads only when its write strobe is high, so the flags can be set up between instructions. Evaluation reads the registered flags together with the incoming instruction word. The enable and the reserved indication are registered, so they appear one clock after the word is presented.

Top module: `predgate_unit`

## Requirements
- R1: The predicate code is taken from bits [INSTR_W-1:INSTR_W-4] of `instr`. No other bit of `instr` changes `exec_ok` or `rsvd_code`.
- R2: Code 0 passes when the zero flag is 1. Code 1 passes when the zero flag is 0.
- R3: Code 2 passes when the carry flag is 1. Code 3 passes when the carry flag is 0.
- R4: Code 4 passes when the negative flag is 1. Code 5 passes when the negative flag is 0.
- R5: Code 6 passes when the overflow flag is 1. Code 7 passes when the overflow flag is 0.
- R6: Code 8 (unsigned greater) passes when carry is 1 and zero is 0. Code 9 passes when carry is 0 or zero is 1, which is exactly the inverse of code 8.
- R7: Code 10 (signed greater or equal) passes when negative equals overflow. Code 11 passes when they differ.
- R8: Code 12 (signed greater) passes when zero is 0 and negative equals overflow. Code 13 passes when zero is 1 or negative differs from overflow.
- R9: Code 14 always passes, with `rsvd_code` low.
- R10: Code 15 never passes. It drives `rsvd_code` high, and `rsvd_code` is never high together with `exec_ok`.
- R11: The flag vector is ordered bit 3 negative, bit 2 zero, bit 1 carry, bit 0 overflow. `flags_q` takes `flag_in` at a rising edge where `flag_we` is 1 and holds its value otherwise.
- R12: `exec_ok` and `rsvd_code` change only at a rising edge. After that edge they reflect the `instr` and `flags_q` values that were present just before it.
- R13: Synchronous active-high reset clears `flags_q`, `exec_ok` and `rsvd_code` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flag_we | input | 1 | Write strobe for the flag register |
| flag_in | input | 4 | New flags: bit 3 negative, bit 2 zero, bit 1 carry, bit 0 overflow |
| instr | input | INSTR_W | Instruction word; the top four bits are the predicate code |
| flags_q | output | 4 | Current content of the flag register |
| exec_ok | output | 1 | Registered pass result for the previous cycle's word |
| rsvd_code | output | 1 | Registered flag that the reserved code was seen |

## Verification
The bench builds the unit with the default word width of 32, so the code field sits at bits 31:28. The lower 28 bits act as free stimulus. Every one of the sixteen flag combinations is loaded, and all sixteen codes are applied against each, with the low bits varied from vector to vector. This covers every compound signed and unsigned relation, and both of the special codes, on every flag pattern. Further directed vectors cover the following:
- a write to the flag register with the strobe low;
- the one-cycle output latency;
- a reset applied while an always-pass code and a flag write are present.

// File: rtl/predgate_pkg.sv
`timescale 1ns/1ps
package predgate_pkg;
  localparam int CODE_W = 4;
  localparam int FLAG_W = 4;

  typedef enum logic [CODE_W-1:0] {
    PRED_ZERO    = 4'd0,
    PRED_NONZERO = 4'd1,
    PRED_CARRY   = 4'd2,
    PRED_NOCARRY = 4'd3,
    PRED_NEG     = 4'd4,
    PRED_NONNEG  = 4'd5,
    PRED_OVF     = 4'd6,
    PRED_NOOVF   = 4'd7,
    PRED_UGT     = 4'd8,
    PRED_ULE     = 4'd9,
    PRED_SGE     = 4'd10,
    PRED_SLT     = 4'd11,
    PRED_SGT     = 4'd12,
    PRED_SLE     = 4'd13,
    PRED_ALWAYS  = 4'd14,
    PRED_RSVD    = 4'd15
  } pred_code_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } flag_vec_t;
endpackage

// File: rtl/predgate_flag_reg.sv
`timescale 1ns/1ps
module predgate_flag_reg
  import predgate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  flag_vec_t d,
  output flag_vec_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/predgate_eval.sv
`timescale 1ns/1ps
module predgate_eval
  import predgate_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  flag_vec_t         flags,
  output logic              pass,
  output logic              rsvd
);
  localparam int NCODES = 1 << CODE_W;
  localparam int NPAIRS = (NCODES - 2) / 2;

  // One base term per even code; the odd neighbour is its complement.
  logic [NPAIRS-1:0] base;
  logic [NCODES-1:0] hit;
  logic              sgn_eq;

  always_comb begin
    sgn_eq  = (flags.neg == flags.ovf);
    base    = '0;
    base[0] = flags.zero;
    base[1] = flags.carry;
    base[2] = flags.neg;
    base[3] = flags.ovf;
    base[4] = flags.carry & ~flags.zero;
    base[5] = sgn_eq;
    base[6] = ~flags.zero & sgn_eq;
  end

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    assign hit[2*p]   = base[p];
    assign hit[2*p+1] = ~base[p];
  end

  assign hit[NCODES-2] = 1'b1;
  assign hit[NCODES-1] = 1'b0;

  assign pass = hit[code];
  assign rsvd = (code == PRED_RSVD);
endmodule

// File: rtl/predgate_out_stage.sv
`timescale 1ns/1ps
module predgate_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic pass_d,
  input  logic rsvd_d,
  output logic pass_q,
  output logic rsvd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pass_q <= 1'b0;
      rsvd_q <= 1'b0;
    end else begin
      pass_q <= pass_d;
      rsvd_q <= rsvd_d;
    end
  end
endmodule

// File: rtl/predgate_unit.sv
`timescale 1ns/1ps
module predgate_unit
  import predgate_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flag_we,
  input  logic [FLAG_W-1:0]  flag_in,
  input  logic [INSTR_W-1:0] instr,
  output logic [FLAG_W-1:0]  flags_q,
  output logic               exec_ok,
  output logic               rsvd_code
);
  localparam int CODE_LSB = INSTR_W - CODE_W;

  flag_vec_t         flag_cur;
  logic [CODE_W-1:0] code;
  logic              pass_c;
  logic              rsvd_c;
  logic              unused_low;

  assign code       = instr[INSTR_W-1:CODE_LSB];
  assign unused_low = ^instr[CODE_LSB-1:0];

  predgate_flag_reg u_flags (
    .clk  (clk),
    .rst  (rst),
    .load (flag_we),
    .d    (flag_vec_t'(flag_in)),
    .q    (flag_cur)
  );

  predgate_eval u_eval (
    .code  (code),
    .flags (flag_cur),
    .pass  (pass_c),
    .rsvd  (rsvd_c)
  );

  predgate_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .pass_d (pass_c),
    .rsvd_d (rsvd_c),
    .pass_q (exec_ok),
    .rsvd_q (rsvd_code)
  );

  assign flags_q = flag_cur;
endmodule

// File: rtl/predgate_chk.sv
`timescale 1ns/1ps
module predgate_chk
  import predgate_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              flag_we,
  input logic [FLAG_W-1:0] flag_in,
  input logic [CODE_W-1:0] cond,
  input logic [FLAG_W-1:0] flags_q,
  input logic              exec_ok,
  input logic              rsvd_code
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!exec_ok && !rsvd_code && flags_q == '0)); // R13
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst) flag_we |=> flags_q == $past(flag_in)); // R11
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst) !flag_we |=> flags_q == $past(flags_q)); // R11
  AST_ALWAYS_PASS: assert property (@(posedge clk) disable iff (rst) cond == 4'd14 |=> (exec_ok && !rsvd_code)); // R9
  AST_RSVD_BLOCKS: assert property (@(posedge clk) disable iff (rst) cond == 4'd15 |=> (!exec_ok && rsvd_code)); // R10
  AST_RSVD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) rsvd_code |-> !exec_ok); // R10
  AST_ZERO_PAIR: assert property (@(posedge clk) disable iff (rst) cond[3:1] == 3'd0 |=> exec_ok == ($past(flags_q[2]) ^ $past(cond[0]))); // R2
  AST_SIGNED_GE: assert property (@(posedge clk) disable iff (rst) cond == 4'd10 |=> exec_ok == ($past(flags_q[3]) == $past(flags_q[0]))); // R7
endmodule

bind predgate_unit predgate_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .flag_we   (flag_we),
  .flag_in   (flag_in),
  .cond      (instr[INSTR_W-1 -: predgate_pkg::CODE_W]),
  .flags_q   (flags_q),
  .exec_ok   (exec_ok),
  .rsvd_code (rsvd_code)
);

// File: tb/tb_predgate_unit.sv
`timescale 1ns/1ps
module tb_predgate_unit;
  localparam int IW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flag_we = 1'b0;
  logic [3:0]    flag_in = '0;
  logic [IW-1:0] instr = '0;
  logic [3:0]    flags_q;
  logic          exec_ok;
  logic          rsvd_code;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  logic drv_valid = 1'b0;
  logic mon_valid = 1'b0;
  logic [3:0] model_flags = '0;

  logic [1:0] exp_q[$];
  string      req_q[$];

  always #5 clk = ~clk;

  predgate_unit #(.INSTR_W(IW)) dut (
    .clk(clk), .rst(rst), .flag_we(flag_we), .flag_in(flag_in),
    .instr(instr), .flags_q(flags_q), .exec_ok(exec_ok), .rsvd_code(rsvd_code)
  );

  // Expected result from the requirement text: {pass, reserved}
  function automatic logic [1:0] model(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return {z, 1'b0};
      4'd1:  return {!z, 1'b0};
      4'd2:  return {cy, 1'b0};
      4'd3:  return {!cy, 1'b0};
      4'd4:  return {n, 1'b0};
      4'd5:  return {!n, 1'b0};
      4'd6:  return {v, 1'b0};
      4'd7:  return {!v, 1'b0};
      4'd8:  return {cy && !z, 1'b0};
      4'd9:  return {!cy || z, 1'b0};
      4'd10: return {n == v, 1'b0};
      4'd11: return {n != v, 1'b0};
      4'd12: return {!z && (n == v), 1'b0};
      4'd13: return {z || (n != v), 1'b0};
      4'd14: return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd1:   return "R2";
      4'd2, 4'd3:   return "R3";
      4'd4, 4'd5:   return "R4";
      4'd6, 4'd7:   return "R5";
      4'd8, 4'd9:   return "R6";
      4'd10, 4'd11: return "R7";
      4'd12, 4'd13: return "R8";
      4'd14:        return "R9";
      default:      return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: present one word and push its expected outcome.
  task automatic drive_vec(input logic [3:0] c, input logic [IW-5:0] low, input string req);
    @(negedge clk);
    instr     = {c, low};
    drv_valid = 1'b1;
    exp_q.push_back(model(c, model_flags));
    req_q.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    drv_valid = 1'b0;
  endtask

  task automatic load_flags(input logic [3:0] f);
    @(negedge clk);
    drv_valid   = 1'b0;
    flag_we     = 1'b1;
    flag_in     = f;
    model_flags = f;
    @(negedge clk);
    flag_we = 1'b0;
    check(flags_q == f, "R11", flags_q, f);
  endtask

  always @(posedge clk) mon_valid <= drv_valid;

  // Monitor: compare registered results against the scoreboard.
  always @(negedge clk) begin
    if (mon_valid) begin
      logic [1:0] e;
      string      r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check({exec_ok, rsvd_code} == e, r, {exec_ok, rsvd_code}, e);
    end
  end

  initial begin
    // R13: reset holds everything at zero despite a flag write and an always-pass code
    flag_we = 1'b1;
    flag_in = 4'hF;
    instr   = {4'd14, 28'h0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(exec_ok == 1'b0, "R13", exec_ok, 0);
    check(rsvd_code == 1'b0, "R13", rsvd_code, 0);
    check(flags_q == 4'h0, "R13", flags_q, 0);
    rst     = 1'b0;
    flag_we = 1'b0;
    flag_in = '0;

    // Exhaustive sweep: all flag patterns against all codes, low bits varied
    for (int f = 0; f < 16; f++) begin
      load_flags(4'(f));
      for (int c = 0; c < 16; c++)
        drive_vec(4'(c), 28'(f * 7919 + c * 104729 + 28'h5A5A5A), tag_of(4'(c)));
    end
    idle();

    // R1: low bits cannot change the outcome
    load_flags(4'b0100);
    drive_vec(4'd1, 28'h0000000, "R1");
    drive_vec(4'd1, 28'hFFFFFFF, "R1");
    drive_vec(4'd0, 28'hFFFFFFF, "R1");
    drive_vec(4'd0, 28'h0000000, "R1");
    idle();

    // R11: a flag write with the strobe low is ignored
    load_flags(4'b0000);
    @(negedge clk);
    flag_in = 4'hF;
    @(negedge clk);
    check(flags_q == 4'h0, "R11", flags_q, 0);
    drive_vec(4'd0, 28'h1234567, "R11");
    drive_vec(4'd4, 28'h7654321, "R11");
    idle();
    check(flags_q == 4'h0, "R11", flags_q, 0);
    flag_in = '0;

    // R12: output holds until the next rising edge
    drive_vec(4'd14, 28'h0, "R12");
    drive_vec(4'd15, 28'h0, "R12");
    #1;
    check(exec_ok == 1'b1, "R12", exec_ok, 1);
    check(rsvd_code == 1'b0, "R12", rsvd_code, 0);
    idle();
    idle();

    check(exp_q.size() == 0, "R12", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule